// File: doc/BRIEF.md
# Segmented Sign-Magnitude Ladder DAC Serializer

This block feeds a resistor-ladder DAC that expects sign-magnitude data. It accepts stereo PCM samples in two's-complement form on a valid/ready interface. Each channel becomes a sign bit plus an unsigned magnitude. The upper magnitude bits are expanded into a thermometer code, so that exactly one ladder element switches per code step in that segment. The lower magnitude bits pass straight through as binary ladder bits.

Each encoded word is shifted out on three wires: a bit clock, a data line and a latch strobe. The left channel goes first and the right channel follows in the same sample period. An optional stopped-clock mode holds the bit clock low whenever no frame is being sent. A one-entry holding register accepts the next sample while the current pair is still being shifted, so an upstream sample strobe at any rate from 44.1 kHz to 192 kHz is never lost.

Parameters select a sample width of 16 or 24 bits, a thermometer segment of 3 or 5 bits, and the bit-clock divider. The frame length is 2^T + (SAMPLE_W-1) - T bits for a thermometer width of T.

Top module: `seg_dac_encoder`

## Requirements
- R1: For a non-negative input the frame sign bit is 0 and the magnitude equals the input. For a negative input the sign bit is 1 and the magnitude is the absolute value.
- R2: The most negative input code (only the MSB set) is sent with sign bit 1 and an all-ones magnitude.
- R3: The top T magnitude bits, read as a value k, drive 2^T-1 thermometer lines. Lines 0 to k-1 are 1 and all others are 0.
- R4: The magnitude bits below the thermometer segment appear in the frame unchanged.
- R5: Frame order on the data line is: sign, then thermometer lines from highest to lowest index, then binary bits MSB first. Data is stable while the bit clock is high.
- R6: After the last data bit of each channel frame there is exactly one bit slot with the latch high and the data line low.
- R7: Within a sample, the left channel frame is sent before the right channel frame, and the two frames are back to back.
- R8: in_ready falls only while an accepted sample waits in the holding register. A waiting sample is never dropped and is sent in order. A new sample can be accepted in the same cycle that the waiting one moves to the shifter.
- R9: With STOP_CLK=1 the bit clock stays low whenever no frame is being shifted.
- R10: One bit slot lasts 2*HALF_DIV clock cycles: the bit clock is low for the first half and high for the second.
- R11: After reset, the bit clock, data and latch are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Sample pair can be taken |
| in_left | input | SAMPLE_W | Left channel, two's complement |
| in_right | input | SAMPLE_W | Right channel, two's complement |
| ser_bck | output | 1 | Serial bit clock (receiver samples on rising edge) |
| ser_data | output | 1 | Serial data |
| ser_latch | output | 1 | Word latch strobe, one bit slot per channel |

## Verification
The critical overlap is the cycle in which the holding register hands its sample to the idle shifter while a new sample is accepted from the input. The bench provokes it by offering three sample pairs back to back. The third pair is then taken at the exact edge on which the second starts shifting. All six decoded frames must arrive in order with matching values, and in_ready must have been low while the second pair waited.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
   typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

   function automatic int therm_lines(input int t);
      return (1 << t) - 1;
   endfunction

   function automatic int frame_bits(input int w, input int t);
      return 1 + therm_lines(t) + (w - 1 - t);
   endfunction
endpackage

// File: rtl/seg_sm_convert.sv
module seg_sm_convert #(
   parameter int W = 16
) (
   input  logic [W-1:0] pcm,
   output logic         sign,
   output logic [W-2:0] mag
);
   localparam int MAG_W = W - 1;
   logic [W-1:0] neg;

   always_comb begin
      sign = pcm[W-1];
      neg  = -pcm;
      if (!sign)
         mag = pcm[W-2:0];
      else if (pcm == {1'b1, {MAG_W{1'b0}}})
         mag = {MAG_W{1'b1}};
      else
         mag = neg[W-2:0];
   end
endmodule

// File: rtl/seg_therm_expand.sv
module seg_therm_expand #(
   parameter int T = 3
) (
   input  logic [T-1:0]                         code,
   output logic [seg_dac_pkg::therm_lines(T)-1:0] lines
);
   localparam int NL = seg_dac_pkg::therm_lines(T);

   for (genvar i = 0; i < NL; i++) begin : g_line
      assign lines[i] = (int'(code) > i);
   end
endmodule

// File: rtl/seg_word_encoder.sv
module seg_word_encoder #(
   parameter int W = 16,
   parameter int T = 3
) (
   input  logic [W-1:0]                            pcm,
   output logic [seg_dac_pkg::frame_bits(W, T)-1:0] frame
);
   localparam int MAG_W = W - 1;
   localparam int LOW_W = MAG_W - T;
   localparam int NL    = seg_dac_pkg::therm_lines(T);

   logic             sign;
   logic [MAG_W-1:0] mag;
   logic [NL-1:0]    lines;

   seg_sm_convert #(.W(W)) u_sm (.pcm(pcm), .sign(sign), .mag(mag));
   seg_therm_expand #(.T(T)) u_th (.code(mag[MAG_W-1 -: T]), .lines(lines));

   assign frame = {sign, lines, mag[LOW_W-1:0]};
endmodule

// File: rtl/seg_frame_shifter.sv
module seg_frame_shifter #(
   parameter int FRAME_W  = 20,
   parameter int HALF_DIV = 2,
   parameter bit STOP_CLK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_l,
   input  logic [FRAME_W-1:0] frame_r,
   output logic               busy,
   output logic               bck,
   output logic               data,
   output logic               latch
);
   import seg_dac_pkg::*;
   localparam int PH_W  = $clog2(2 * HALF_DIV);
   localparam int BIT_W = $clog2(FRAME_W + 1);

   logic [PH_W-1:0]    ph_q;
   logic [BIT_W-1:0]   bit_q;
   chan_e              chan_q;
   logic               busy_q;
   logic [FRAME_W-1:0] sreg_q, rsv_q;
   logic               ph_end, slot_latch;

   assign ph_end     = (ph_q == PH_W'(2 * HALF_DIV - 1));
   assign slot_latch = (bit_q == BIT_W'(FRAME_W));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= '0;
         bit_q  <= '0;
         chan_q <= CH_LEFT;
         busy_q <= 1'b0;
         sreg_q <= '0;
         rsv_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         ph_q   <= '0;
         bit_q  <= '0;
         chan_q <= CH_LEFT;
         sreg_q <= frame_l;
         rsv_q  <= frame_r;
      end else if (busy_q) begin
         ph_q <= ph_end ? '0 : ph_q + PH_W'(1);
         if (ph_end) begin
            if (slot_latch) begin
               bit_q <= '0;
               if (chan_q == CH_LEFT) begin
                  chan_q <= CH_RIGHT;
                  sreg_q <= rsv_q;
               end else begin
                  busy_q <= 1'b0;
               end
            end else begin
               bit_q  <= bit_q + BIT_W'(1);
               sreg_q <= sreg_q << 1;
            end
         end
      end else if (!STOP_CLK) begin
         ph_q <= ph_end ? '0 : ph_q + PH_W'(1);
      end
   end

   if (STOP_CLK) begin : g_stop_clk
      assign bck = busy_q && (ph_q >= PH_W'(HALF_DIV));
   end else begin : g_free_clk
      assign bck = (ph_q >= PH_W'(HALF_DIV));
   end

   assign busy  = busy_q;
   assign data  = busy_q && !slot_latch && sreg_q[FRAME_W-1];
   assign latch = busy_q && slot_latch;
endmodule

// File: rtl/seg_dac_encoder.sv
module seg_dac_encoder #(
   parameter int SAMPLE_W = 16,
   parameter int THERM_W  = 3,
   parameter int HALF_DIV = 2,
   parameter bit STOP_CLK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                ser_bck,
   output logic                ser_data,
   output logic                ser_latch
);
   localparam int FRAME_W = seg_dac_pkg::frame_bits(SAMPLE_W, THERM_W);

   if (!(SAMPLE_W == 16 || SAMPLE_W == 24)) begin : g_bad_width
      $error("SAMPLE_W must be 16 or 24");
   end
   if (!(THERM_W == 3 || THERM_W == 5)) begin : g_bad_therm
      $error("THERM_W must be 3 or 5");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic                pend_q;
   logic [SAMPLE_W-1:0] hold_q [2];
   logic [FRAME_W-1:0]  frame  [2];
   logic                busy, load;

   assign load     = pend_q && !busy;
   assign in_ready = !pend_q || load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         hold_q[0] <= '0;
         hold_q[1] <= '0;
      end else if (in_valid && in_ready) begin
         pend_q    <= 1'b1;
         hold_q[0] <= in_left;
         hold_q[1] <= in_right;
      end else if (load) begin
         pend_q <= 1'b0;
      end
   end

   for (genvar c = 0; c < 2; c++) begin : g_chan
      seg_word_encoder #(.W(SAMPLE_W), .T(THERM_W)) u_enc (
         .pcm   (hold_q[c]),
         .frame (frame[c])
      );
   end

   seg_frame_shifter #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV), .STOP_CLK(STOP_CLK)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .frame_l (frame[0]),
      .frame_r (frame[1]),
      .busy    (busy),
      .bck     (ser_bck),
      .data    (ser_data),
      .latch   (ser_latch)
   );
endmodule

// File: rtl/seg_dac_encoder_chk.sv
module seg_dac_encoder_chk #(
   parameter bit STOP_CLK = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic ser_bck,
   input logic ser_data,
   input logic ser_latch,
   input logic busy,
   input logic pend
);
   assert_latch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> !ser_data);

   assert_latch_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_latch) |=> ser_latch);

   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_bck && $past(ser_bck)) |-> $stable(ser_data));

   assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && busy) |=> pend);

   assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> pend);

   if (STOP_CLK) begin : g_stop_chk
      assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !busy |-> !ser_bck);
   end
endmodule

bind seg_dac_encoder seg_dac_encoder_chk #(.STOP_CLK(STOP_CLK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .ser_bck   (ser_bck),
   .ser_data  (ser_data),
   .ser_latch (ser_latch),
   .busy      (busy),
   .pend      (pend_q)
);

// File: tb/tb_seg_dac_encoder.sv
module tb_seg_dac_encoder;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 16;
   localparam int T     = 3;
   localparam int HALF  = 2;
   localparam int NL    = (1 << T) - 1;
   localparam int LOW_W = W - 1 - T;
   localparam int FW    = 1 + NL + LOW_W;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic [W-1:0] in_left = '0, in_right = '0;
   logic in_ready, ser_bck, ser_data, ser_latch;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_dac_encoder #(.SAMPLE_W(W), .THERM_W(T), .HALF_DIV(HALF), .STOP_CLK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_left(in_left), .in_right(in_right),
      .ser_bck(ser_bck), .ser_data(ser_data), .ser_latch(ser_latch));

   // serial monitor: samples at negedge, decodes on rising bit clock
   logic [FW-1:0] got_q[$];
   logic [FW-1:0] fbuf = '0;
   logic prev_bck = 1'b0;
   int nbits = 0, cyc = 0, last_rise = 0;
   int period_bad = 0, latch_bad = 0, len_bad = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!prev_bck && ser_bck) begin
            if (nbits > 0 && (cyc - last_rise) != 2 * HALF) period_bad++;
            last_rise = cyc;
            if (ser_latch) begin
               if (ser_data) latch_bad++;
               if (nbits != FW) len_bad++;
               got_q.push_back(fbuf);
               nbits = 0;
            end else begin
               fbuf = {fbuf[FW-2:0], ser_data};
               nbits++;
            end
         end
         prev_bck = ser_bck;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_val(input int x);
      if (x == -(1 << (W - 1))) return -((1 << (W - 1)) - 1);
      return x;
   endfunction

   function automatic logic [FW-1:0] exp_frame(input int x);
      int v = exp_val(x);
      int m = (v < 0) ? -v : v;
      int k = m >> LOW_W;
      logic [NL-1:0] th = NL'((1 << k) - 1);
      return {logic'(v < 0), th, LOW_W'(m)};
   endfunction

   function automatic int dec_val(input logic [FW-1:0] f);
      int k = $countones(f[FW-2 -: NL]);
      int m = (k << LOW_W) | int'(f[LOW_W-1:0]);
      return f[FW-1] ? -m : m;
   endfunction

   task automatic send(input int l, input int r);
      @(negedge clk);
      in_valid = 1'b1;
      in_left  = W'(l);
      in_right = W'(r);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      int guard = 0;
      while (got_q.size() < n && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic check_frame(input int x, input string req);
      logic [FW-1:0] f;
      if (got_q.size() == 0) begin
         check(1'b0, req, 0, 1);
         return;
      end
      f = got_q.pop_front();
      check(dec_val(f) == exp_val(x), req, dec_val(f), exp_val(x));
      check(f == exp_frame(x), "R4 R5 frame bits", int'(f), int'(exp_frame(x)));
      check(f[FW-2 -: NL] == NL'((1 << $countones(f[FW-2 -: NL])) - 1),
            "R3 thermometer shape", int'(f[FW-2 -: NL]), 0);
   endtask

   task automatic t_reset();
      check(!ser_bck && !ser_data && !ser_latch, "R11 outputs low", int'({ser_bck, ser_data, ser_latch}), 0);
      check(in_ready, "R11 ready", int'(in_ready), 1);
   endtask

   task automatic t_pair(input int l, input int r, input string req);
      send(l, r);
      wait_frames(2);
      check_frame(l, {req, " R7 left"});
      check_frame(r, {req, " R7 right"});
   endtask

   task automatic t_back_to_back();
      send(300, -300);
      send(-4096, 4095);
      @(negedge clk);
      check(!in_ready, "R8 ready low while held", int'(in_ready), 0);
      send(32767, -32768);
      wait_frames(6);
      check(got_q.size() == 6, "R8 no frame lost", got_q.size(), 6);
      check_frame(300, "R8 first L");
      check_frame(-300, "R8 first R");
      check_frame(-4096, "R8 second L");
      check_frame(4095, "R8 second R");
      check_frame(32767, "R8 third L");
      check_frame(-32768, "R8 R2 third R");
   endtask

   task automatic t_idle();
      int high = 0;
      repeat (40) begin
         @(negedge clk);
         if (ser_bck) high++;
      end
      check(high == 0, "R9 stopped clock idle", high, 0);
   endtask

   task automatic t_timing();
      check(period_bad == 0, "R10 bit slot length", period_bad, 0);
      check(latch_bad == 0, "R6 data low in latch slot", latch_bad, 0);
      check(len_bad == 0, "R5 R6 frame length before latch", len_bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_pair(0, 0, "R1 zero");
      t_pair(1, -1, "R1 unit");
      t_pair(32767, -32768, "R2 full scale and clamp");
      t_pair(4095, 4096, "R3 R4 segment edge");
      t_pair(4660, -22136, "R1 pattern");
      t_back_to_back();
      t_idle();
      t_timing();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule